// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Controller

This block sits around an external per-lane arithmetic unit, such as a packed single-precision divider, in a vector pipeline whose registers are up to 512 bits wide and split into 32-bit lanes. On the way in, it forms the two operand vectors. The second operand is either taken lane by lane or, for a memory source in the masked class, built by repeating one 32-bit scalar. The block also chooses whether the instruction's own rounding field or the global rounding field applies.

On the way out, it takes the lane results from the arithmetic unit and builds the final 512-bit destination. Each lane is handled according to the write mask and the merge/zero choice. The bits above the active vector length are either cleared or kept, depending on the encoding class.

The block has two register stages. A request produces registered operands and a rounding mode on the next edge. A result-valid pulse produces the registered destination on the edge after it, using the context of the most recent request.

Top module: `simd_wb_ctrl`

## Requirements
- R1: The active lane count depends on the class and the length code. Class 0 (legacy) always uses 4 lanes. Class 1 (three-operand, unmasked) uses 4 lanes for length 0 and 8 lanes otherwise. Classes 2 and 3 (masked) use 4 lanes for length 0, 8 for length 1 and 16 for lengths 2 and 3.
- R2: One cycle after req_valid_i, op_valid_o is high. Lane j (bits j*32+31:j*32) of op_a_o equals the same lane of src1_i for every active lane. Both operand outputs are zero in every lane at or above the active count.
- R3: In the masked classes, with bcast_i=1 and src2_mem_i=1, every active lane of op_b_o equals src2_i[31:0]. In every other case, lane j of op_b_o equals lane j of src2_i, so bcast_i has no effect outside the masked classes.
- R4: rnd_mode_o takes rc_embed_i only when the class is masked, the length code is 2 or 3, bcast_i=1 and src2_mem_i=0. In every other case it takes rc_global_i.
- R5: The write mask applies only when the class is masked and mask_en_i=1. In that case an active lane j takes its result lane when mask_i[j]=1. Otherwise every active lane takes its result lane. Mask bits at or above the active lane count are ignored, and mask_en_i is ignored in classes 0 and 1.
- R6: An active lane that the mask does not select becomes zero when zero_i=1, and keeps the corresponding old_dst_i lane when zero_i=0.
- R7: In classes 1, 2 and 3, every destination bit from the active length up to bit 511 is zero.
- R8: In class 0, destination bits 511:128 equal old_dst_i as captured with the request.
- R9: dst_valid_o is high exactly one cycle after res_valid_i. dst_o is merged from res_i and the context of the latest request.
- R10: After reset, op_valid_o, dst_valid_o and dst_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| enc_class_i | input | 2 | 0 legacy, 1 three-operand, 2/3 masked |
| len_sel_i | input | 2 | Vector length code |
| mask_en_i | input | 1 | Write mask in use |
| zero_i | input | 1 | 1 zero masking, 0 merge masking |
| bcast_i | input | 1 | Broadcast / rounding flag |
| src2_mem_i | input | 1 | Second source is memory |
| mask_i | input | 16 | Per-lane write mask |
| rc_embed_i | input | 2 | Instruction rounding field |
| rc_global_i | input | 2 | Global rounding field |
| src1_i | input | 512 | First source vector |
| src2_i | input | 512 | Second source vector or fetched scalar |
| old_dst_i | input | 512 | Previous destination contents |
| op_valid_o | output | 1 | Operands valid |
| op_a_o | output | 512 | Lane first operands |
| op_b_o | output | 512 | Lane second operands |
| rnd_mode_o | output | 2 | Selected rounding mode |
| res_valid_i | input | 1 | Lane results valid |
| res_i | input | 512 | Lane results |
| dst_valid_o | output | 1 | Destination valid |
| dst_o | output | 512 | Merged destination |

## Verification
The operand outputs and the rounding mode are due at the first rising edge after req_valid_i. The merged destination is due at the first rising edge after res_valid_i. The bench drives each strobe for one cycle, starting at a falling edge, and compares the outputs at the following falling edge. That comparison point is half a cycle after the single register stage in each path has updated and before any further input changes.

// File: rtl/simd_wb_pkg.sv
package simd_wb_pkg;
  parameter int unsigned LANE_W = 32;
  parameter int unsigned LANES  = 16;
  parameter int unsigned VEC_W  = LANE_W * LANES;
  parameter int unsigned BASE_LANES = 128 / LANE_W;
  parameter int unsigned CNT_W  = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    ENC_LEG = 2'd0,
    ENC_TRI = 2'd1,
    ENC_MSK = 2'd2,
    ENC_MSK_ALT = 2'd3
  } enc_class_e;

  typedef enum logic [1:0] {
    LP_RES  = 2'd0,
    LP_OLD  = 2'd1,
    LP_ZERO = 2'd2
  } lane_pol_e;
endpackage

// File: rtl/simd_wb_decode.sv
module simd_wb_decode
  import simd_wb_pkg::*;
(
  input  logic [1:0]             enc_i,
  input  logic [1:0]             len_i,
  input  logic                   mask_en_i,
  input  logic                   zero_i,
  input  logic                   bcast_i,
  input  logic                   mem_i,
  input  logic [LANES-1:0]       mask_i,
  output logic [CNT_W-1:0]       n_lanes_o,
  output logic [LANES-1:0]       lane_act_o,
  output lane_pol_e [LANES-1:0]  pol_o,
  output logic                   bcast_use_o,
  output logic                   rc_ovr_o
);
  logic       is_msk, is_leg, mask_use;
  logic [1:0] lcode;

  assign is_msk = enc_i[1];
  assign is_leg = (enc_i == ENC_LEG);

  always_comb begin
    if (is_leg)       lcode = 2'd0;
    else if (!is_msk) lcode = {1'b0, len_i != 2'd0};
    else              lcode = len_i[1] ? 2'd2 : {1'b0, len_i[0]};
  end

  assign n_lanes_o   = CNT_W'(BASE_LANES << lcode);
  assign mask_use    = is_msk & mask_en_i;
  assign bcast_use_o = is_msk & bcast_i & mem_i;
  assign rc_ovr_o    = is_msk & (lcode == 2'd2) & bcast_i & ~mem_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_act_o[j] = (j < int'(n_lanes_o));
    always_comb begin
      if (lane_act_o[j]) begin
        if (!mask_use || mask_i[j]) pol_o[j] = LP_RES;
        else if (zero_i)            pol_o[j] = LP_ZERO;
        else                        pol_o[j] = LP_OLD;
      end else begin
        pol_o[j] = is_leg ? LP_OLD : LP_ZERO;
      end
    end
  end

  // R5
  always_comb begin
    for (int j = 0; j < LANES; j++)
      if (j >= int'(n_lanes_o))
        inactive_no_result_chk: assert (pol_o[j] != LP_RES);
  end
endmodule

// File: rtl/simd_wb_opnd.sv
module simd_wb_opnd
  import simd_wb_pkg::*;
(
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [LANES-1:0] lane_act_i,
  input  logic             bcast_i,
  output logic [VEC_W-1:0] op_a_o,
  output logic [VEC_W-1:0] op_b_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] b_sel;
    assign b_sel = bcast_i ? src2_i[LANE_W-1:0] : src2_i[j*LANE_W +: LANE_W];
    assign op_a_o[j*LANE_W +: LANE_W] = lane_act_i[j] ? src1_i[j*LANE_W +: LANE_W] : '0;
    assign op_b_o[j*LANE_W +: LANE_W] = lane_act_i[j] ? b_sel : '0;
  end
endmodule

// File: rtl/simd_wb_merge.sv
module simd_wb_merge
  import simd_wb_pkg::*;
(
  input  lane_pol_e [LANES-1:0] pol_i,
  input  logic [VEC_W-1:0]      res_i,
  input  logic [VEC_W-1:0]      old_i,
  output logic [VEC_W-1:0]      dst_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      unique case (pol_i[j])
        LP_RES:  dst_o[j*LANE_W +: LANE_W] = res_i[j*LANE_W +: LANE_W];
        LP_OLD:  dst_o[j*LANE_W +: LANE_W] = old_i[j*LANE_W +: LANE_W];
        default: dst_o[j*LANE_W +: LANE_W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/simd_wb_ctrl.sv
module simd_wb_ctrl
  import simd_wb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       enc_class_i,
  input  logic [1:0]       len_sel_i,
  input  logic             mask_en_i,
  input  logic             zero_i,
  input  logic             bcast_i,
  input  logic             src2_mem_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [1:0]       rc_embed_i,
  input  logic [1:0]       rc_global_i,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [VEC_W-1:0] old_dst_i,
  output logic             op_valid_o,
  output logic [VEC_W-1:0] op_a_o,
  output logic [VEC_W-1:0] op_b_o,
  output logic [1:0]       rnd_mode_o,
  input  logic             res_valid_i,
  input  logic [VEC_W-1:0] res_i,
  output logic             dst_valid_o,
  output logic [VEC_W-1:0] dst_o
);
  logic [CNT_W-1:0]      n_lanes;
  logic [LANES-1:0]      lane_act;
  lane_pol_e [LANES-1:0] pol_d, pol_q;
  logic                  bcast_use, rc_ovr;
  logic [VEC_W-1:0]      op_a_d, op_b_d, old_q, dst_d;
  logic                  leg_q;

  simd_wb_decode u_decode (
    .enc_i       (enc_class_i),
    .len_i       (len_sel_i),
    .mask_en_i   (mask_en_i),
    .zero_i      (zero_i),
    .bcast_i     (bcast_i),
    .mem_i       (src2_mem_i),
    .mask_i      (mask_i),
    .n_lanes_o   (n_lanes),
    .lane_act_o  (lane_act),
    .pol_o       (pol_d),
    .bcast_use_o (bcast_use),
    .rc_ovr_o    (rc_ovr)
  );

  simd_wb_opnd u_opnd (
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .lane_act_i (lane_act),
    .bcast_i    (bcast_use),
    .op_a_o     (op_a_d),
    .op_b_o     (op_b_d)
  );

  // stage one: operands, rounding mode and merge context
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0;
      op_a_o     <= '0;
      op_b_o     <= '0;
      rnd_mode_o <= '0;
      pol_q      <= {LANES{LP_ZERO}};
      old_q      <= '0;
      leg_q      <= 1'b0;
    end else begin
      op_valid_o <= req_valid_i;
      if (req_valid_i) begin
        op_a_o     <= op_a_d;
        op_b_o     <= op_b_d;
        rnd_mode_o <= rc_ovr ? rc_embed_i : rc_global_i;
        pol_q      <= pol_d;
        old_q      <= old_dst_i;
        leg_q      <= (enc_class_i == ENC_LEG);
      end
    end
  end

  simd_wb_merge u_merge (
    .pol_i (pol_q),
    .res_i (res_i),
    .old_i (old_q),
    .dst_o (dst_d)
  );

  // stage two: merged destination
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_valid_o <= 1'b0;
      dst_o       <= '0;
    end else begin
      dst_valid_o <= res_valid_i;
      if (res_valid_i) dst_o <= dst_d;
    end
  end

  // R2
  op_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> op_valid_o);

  // R4
  rnd_global_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !enc_class_i[1]) |=> rnd_mode_o == $past(rc_global_i));

  // R8
  legacy_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && leg_q) |=> dst_o[VEC_W-1:128] == $past(old_q[VEC_W-1:128]));

  // R9
  dst_follows_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> dst_valid_o);

  // R9
  dst_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(dst_o));
endmodule

// File: tb/simd_wb_ctrl_tb.sv
module simd_wb_ctrl_tb;
  localparam int LW = 32;
  localparam int NL = 16;
  localparam int VW = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, res_valid = 1'b0;
  logic [1:0]    enc = '0, len = '0, rc_emb = '0, rc_glb = '0;
  logic          mask_en = 1'b0, zero = 1'b0, bcast = 1'b0, mem = 1'b0;
  logic [NL-1:0] mask = '0;
  logic [VW-1:0] src1 = '0, src2 = '0, old = '0, res = '0;
  logic          op_valid, dst_valid;
  logic [VW-1:0] op_a, op_b, dst;
  logic [1:0]    rnd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  simd_wb_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .enc_class_i(enc),
    .len_sel_i(len), .mask_en_i(mask_en), .zero_i(zero), .bcast_i(bcast),
    .src2_mem_i(mem), .mask_i(mask), .rc_embed_i(rc_emb), .rc_global_i(rc_glb),
    .src1_i(src1), .src2_i(src2), .old_dst_i(old), .op_valid_o(op_valid),
    .op_a_o(op_a), .op_b_o(op_b), .rnd_mode_o(rnd), .res_valid_i(res_valid),
    .res_i(res), .dst_valid_o(dst_valid), .dst_o(dst)
  );

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < NL; k++) v[k*LW +: LW] = $urandom;
    return v;
  endfunction

  // R1
  function automatic int lanes_of();
    if (enc == 2'd0) return 4;
    if (enc == 2'd1) return (len == 2'd0) ? 4 : 8;
    return (len == 2'd0) ? 4 : (len == 2'd1) ? 8 : 16;
  endfunction

  function automatic logic [VW-1:0] exp_a();
    logic [VW-1:0] v = '0;
    for (int j = 0; j < lanes_of(); j++) v[j*LW +: LW] = src1[j*LW +: LW];
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_b();
    logic [VW-1:0] v = '0;
    for (int j = 0; j < lanes_of(); j++)
      v[j*LW +: LW] = (enc[1] && bcast && mem) ? src2[LW-1:0] : src2[j*LW +: LW];
    return v;
  endfunction

  function automatic logic [1:0] exp_rnd();
    return (enc[1] && len[1] && bcast && !mem) ? rc_emb : rc_glb;
  endfunction

  function automatic logic [VW-1:0] exp_dst(input logic [VW-1:0] r, input logic [VW-1:0] o);
    logic [VW-1:0] v = '0;
    for (int j = 0; j < NL; j++) begin
      if (j < lanes_of()) begin
        if (!(enc[1] && mask_en) || mask[j]) v[j*LW +: LW] = r[j*LW +: LW];
        else if (!zero)                      v[j*LW +: LW] = o[j*LW +: LW];
      end else if (enc == 2'd0) begin
        v[j*LW +: LW] = o[j*LW +: LW];
      end
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string what, input logic [VW-1:0] act,
                       input logic [VW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  task automatic run_vec();
    logic [VW-1:0] ea, eb, ed, old_cap;
    logic [1:0]    er;
    ea = exp_a(); eb = exp_b(); er = exp_rnd(); old_cap = old;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(op_valid === 1'b1, "R2 op_valid", VW'(op_valid), VW'(1));
    check(op_a === ea, "R1 R2 op_a", op_a, ea);
    check(op_b === eb, "R3 op_b", op_b, eb);
    check(rnd === er, "R4 rnd_mode", VW'(rnd), VW'(er));
    res = rand_vec();
    ed = exp_dst(res, old_cap);
    old = rand_vec(); // later change must not affect captured context
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    check(dst_valid === 1'b1, "R9 dst_valid", VW'(dst_valid), VW'(1));
    check(dst === ed, "R5 R6 R7 R8 R9 dst", dst, ed);
  endtask

  task automatic rand_fields();
    mask_en = $urandom; zero = $urandom; bcast = $urandom; mem = $urandom;
    mask = $urandom; rc_emb = $urandom; rc_glb = $urandom;
    src1 = rand_vec(); src2 = rand_vec(); old = rand_vec();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    // R10
    check(op_valid === 1'b0, "R10 op_valid reset", VW'(op_valid), '0);
    check(dst_valid === 1'b0, "R10 dst_valid reset", VW'(dst_valid), '0);
    check(dst === '0, "R10 dst reset", dst, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed sweep over classes, lengths and flag combinations
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++)
        for (int f = 0; f < 4; f++) begin
          rand_fields();
          enc = 2'(c); len = 2'(l); bcast = f[0]; mem = f[1];
          rc_emb = 2'd3; rc_glb = 2'd1;
          run_vec();
        end
    // R5 R6: masks with upper bits set, merge vs zero, mask_en off
    for (int z = 0; z < 2; z++)
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 4; c++) begin
          rand_fields();
          enc = 2'(c); len = 2'd1; zero = z[0]; mask_en = e[0]; mask = 16'hFF5A;
          run_vec();
        end
    // R4: override only when masked, 512, broadcast flag, register source
    rand_fields(); enc = 2'd2; len = 2'd2; bcast = 1'b1; mem = 1'b0;
    rc_emb = 2'd2; rc_glb = 2'd0; run_vec();
    rand_fields(); enc = 2'd2; len = 2'd1; bcast = 1'b1; mem = 1'b0;
    rc_emb = 2'd2; rc_glb = 2'd0; run_vec();
    // random mix
    for (int k = 0; k < 400; k++) begin
      rand_fields(); enc = $urandom; len = $urandom;
      run_vec();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule